// File: doc/BRIEF.md
# Trigger-Stopped Ring Sampler Controller

This block is the digital control path of a circular analog sample store. A write position sweeps cell by cell around a ring on every sample clock. A trigger halts it, either on the same edge or after a programmable number of further clocks. The halt position is held as the stop address. A readout strobe then plays out a region of interest: a programmed count of cell addresses, starting at the stop address and climbing modulo the ring length. Each address is split into a channel number and a cell number.

The store has eight channels of 1024 cells each. A two-bit partition input chains them into longer rings. Once a readout finishes, sampling resumes from the stop cell. A rearm pulse ends a stop or a readout early and returns to sampling. The analog sampling and the digitization are not part of this block.

Top module: `ring_stop_ctrl`

## Requirements
- R1: While reset is asserted, the write address is 0, `sampling` is 1 and `rd_valid` is 0.
- R2: While sampling, the write address rises by one on every clock and wraps to 0 after ring length L-1. L is 1024 << `cfg_mode`: mode 0 is 8x1024, 1 is 4x2048, 2 is 2x4096, and 3 is a single 8192-cell ring.
- R3: A trigger with `cfg_delay` = 0 freezes the write address at the value it held on the trigger edge. That value appears on `stop_addr`, and `sampling` is 0 from the next cycle.
- R4: A trigger with `cfg_delay` = D > 0 keeps sampling for D more clocks. The ring then freezes, and the stop address is the trigger-edge address plus D, modulo L.
- R5: A trigger that arrives during the delay, while stopped or during readout, has no effect on the stop address or the write address.
- R6: A readout strobe while stopped raises `rd_valid` on the next cycle for exactly N consecutive cycles. The first address is `stop_addr`, and each later one is the previous address plus one, modulo L. N is `cfg_roi`; when `cfg_roi` is 0 or greater than L, N = L.
- R7: During readout, the combined address A appears as `rd_ch` = A / 1024 and `rd_cell` = A mod 1024.
- R8: On the cycle after the last valid readout cycle, `sampling` is 1. The write address then advances from the stop address.
- R9: A rearm pulse while stopped or reading returns to sampling on the next cycle, with `rd_valid` at 0.
- R10: A readout strobe while sampling (including during the delay) has no effect, and `rd_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Trigger request |
| rearm | input | 1 | Abort stop/readout and resume sampling |
| rd_go | input | 1 | Start region-of-interest readout |
| cfg_delay | input | 8 | Extra clocks between trigger and halt |
| cfg_roi | input | 14 | Number of cells to read (0 = whole ring) |
| cfg_mode | input | 2 | Ring partition: ring length 1024 << mode |
| sampling | output | 1 | Write address is running |
| wr_cell | output | 13 | Current write address in the ring |
| stop_addr | output | 13 | Latched stop address |
| rd_valid | output | 1 | Readout address valid |
| rd_ch | output | 3 | Channel of the readout address |
| rd_cell | output | 10 | Cell of the readout address within its channel |

## Verification
The assertions take the configuration inputs as static while the ring is halted or being read. They also assume `cfg_mode` never shrinks the ring below the current write address. Under those conditions the address-step properties reduce to "previous plus one, or zero". The bench changes `cfg_mode`, `cfg_delay` and `cfg_roi` only while sampling, and only when the write address lies inside the new ring. It moves through the partition modes in rising order so that the ring only grows.

// File: rtl/ring_stop_ctrl.sv
module ring_stop_ctrl #(
  parameter int CELLS_PER_CH = 1024,
  parameter int NUM_CH       = 8,
  parameter int DLY_W        = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               trig,
  input  logic                               rearm,
  input  logic                               rd_go,
  input  logic [DLY_W-1:0]                   cfg_delay,
  input  logic [$clog2(CELLS_PER_CH*NUM_CH):0] cfg_roi,
  input  logic [1:0]                         cfg_mode,
  output logic                               sampling,
  output logic [$clog2(CELLS_PER_CH*NUM_CH)-1:0] wr_cell,
  output logic [$clog2(CELLS_PER_CH*NUM_CH)-1:0] stop_addr,
  output logic                               rd_valid,
  output logic [$clog2(NUM_CH)-1:0]          rd_ch,
  output logic [$clog2(CELLS_PER_CH)-1:0]    rd_cell
);
  localparam int AW     = $clog2(CELLS_PER_CH*NUM_CH);
  localparam int LW     = AW + 1;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int CELL_W = $clog2(CELLS_PER_CH);

  typedef enum logic [1:0] {S_RUN, S_HOLD, S_STOP, S_READ} st_t;
  st_t state;

  logic [AW-1:0]    wr_ptr, rd_addr;
  logic [DLY_W-1:0] hold_cnt;
  logic [LW-1:0]    left;
  logic [1:0]       mode_eff;
  logic [LW-1:0]    ring_len, roi_eff, wr_p1, rd_p1;
  logic [AW-1:0]    wr_nx, rd_nx;

  assign mode_eff = (32'(cfg_mode) > CH_W) ? 2'(CH_W) : cfg_mode;
  assign ring_len = LW'(CELLS_PER_CH) << mode_eff;
  assign roi_eff  = (cfg_roi == '0 || cfg_roi > ring_len) ? ring_len : cfg_roi;

  assign wr_p1 = {1'b0, wr_ptr} + LW'(1);
  assign rd_p1 = {1'b0, rd_addr} + LW'(1);
  assign wr_nx = (wr_p1 >= ring_len) ? '0 : wr_p1[AW-1:0];
  assign rd_nx = (rd_p1 >= ring_len) ? '0 : rd_p1[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_RUN;
      wr_ptr    <= '0;
      stop_addr <= '0;
      hold_cnt  <= '0;
      rd_addr   <= '0;
      left      <= '0;
    end else begin
      case (state)
        S_RUN: begin
          if (trig && cfg_delay == '0) begin
            state     <= S_STOP;
            stop_addr <= wr_ptr;
          end else begin
            if (trig) begin
              state    <= S_HOLD;
              hold_cnt <= cfg_delay;
            end
            wr_ptr <= wr_nx;
          end
        end
        S_HOLD: begin
          if (hold_cnt == DLY_W'(1)) begin
            state     <= S_STOP;
            stop_addr <= wr_ptr;
          end else begin
            hold_cnt <= hold_cnt - DLY_W'(1);
            wr_ptr   <= wr_nx;
          end
        end
        S_STOP: begin
          if (rearm) state <= S_RUN;
          else if (rd_go) begin
            state   <= S_READ;
            rd_addr <= stop_addr;
            left    <= roi_eff;
          end
        end
        default: begin
          if (rearm || left == LW'(1)) state <= S_RUN;
          else begin
            rd_addr <= rd_nx;
            left    <= left - LW'(1);
          end
        end
      endcase
    end
  end

  assign sampling = (state == S_RUN) || (state == S_HOLD);
  assign rd_valid = (state == S_READ);
  assign wr_cell  = wr_ptr;
  assign rd_ch    = rd_addr[AW-1:CELL_W];
  assign rd_cell  = rd_addr[CELL_W-1:0];
endmodule

module ring_stop_ctrl_chk #(
  parameter int AW     = 13,
  parameter int CH_W   = 3,
  parameter int CELL_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rearm,
  input logic              sampling,
  input logic [AW-1:0]     wr_cell,
  input logic [AW-1:0]     stop_addr,
  input logic              rd_valid,
  input logic [CH_W-1:0]   rd_ch,
  input logic [CELL_W-1:0] rd_cell
);
  logic [AW-1:0] rd_full;
  assign rd_full = {rd_ch, rd_cell};

  assert_wr_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sampling && $past(sampling)) |->
      ({1'b0, wr_cell} == {1'b0, $past(wr_cell)} + 1'b1 || wr_cell == '0));

  assert_stop_at_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sampling) |-> (wr_cell == stop_addr));

  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampling && $past(!sampling)) |-> $stable(wr_cell));

  assert_first_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (rd_full == stop_addr));

  assert_rd_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |->
      ({1'b0, rd_full} == {1'b0, $past(rd_full)} + 1'b1 || rd_full == '0));

  assert_rd_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !sampling);

  assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !sampling) |=> (sampling && !rd_valid));

  assert_no_rd_while_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |=> !rd_valid);
endmodule

bind ring_stop_ctrl ring_stop_ctrl_chk #(.AW(AW), .CH_W(CH_W), .CELL_W(CELL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rearm(rearm), .sampling(sampling),
  .wr_cell(wr_cell), .stop_addr(stop_addr), .rd_valid(rd_valid),
  .rd_ch(rd_ch), .rd_cell(rd_cell)
);

// File: tb/sim_ring_stop_ctrl.sv
`timescale 1ns/1ps
module sim_ring_stop_ctrl;
  logic        clk = 0, rst_n = 0, trig = 0, rearm = 0, rd_go = 0;
  logic [7:0]  cfg_delay = 0;
  logic [13:0] cfg_roi = 100;
  logic [1:0]  cfg_mode = 0;
  logic        sampling, rd_valid;
  logic [12:0] wr_cell, stop_addr;
  logic [2:0]  rd_ch;
  logic [9:0]  rd_cell;

  always #10 clk = ~clk;

  ring_stop_ctrl u0 (.clk(clk), .rst_n(rst_n), .trig(trig), .rearm(rearm), .rd_go(rd_go),
    .cfg_delay(cfg_delay), .cfg_roi(cfg_roi), .cfg_mode(cfg_mode), .sampling(sampling),
    .wr_cell(wr_cell), .stop_addr(stop_addr), .rd_valid(rd_valid), .rd_ch(rd_ch), .rd_cell(rd_cell));

  int total = 0, bad = 0;
  string cur = "R2";
  int m_state = 0, m_ptr = 0, m_stop = 0, m_cnt = 0, m_addr = 0, m_left = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ring_l();
    return 1024 << cfg_mode;
  endfunction

  task automatic model_step();
    int l = ring_l();
    int n = (cfg_roi == 0 || int'(cfg_roi) > l) ? l : int'(cfg_roi);
    if (m_state == 0) begin
      if (trig && cfg_delay == 0) begin m_state = 2; m_stop = m_ptr; end
      else begin
        if (trig) begin m_state = 1; m_cnt = cfg_delay; end
        m_ptr = (m_ptr + 1) % l;
      end
    end else if (m_state == 1) begin
      if (m_cnt == 1) begin m_state = 2; m_stop = m_ptr; end
      else begin m_cnt--; m_ptr = (m_ptr + 1) % l; end
    end else if (m_state == 2) begin
      if (rearm) m_state = 0;
      else if (rd_go) begin m_state = 3; m_addr = m_stop; m_left = n; end
    end else begin
      if (rearm || m_left == 1) m_state = 0;
      else begin m_left--; m_addr = (m_addr + 1) % l; end
    end
  endtask

  task automatic compare();
    chk(int'(wr_cell) == m_ptr, {cur, " write address"}, wr_cell, m_ptr);
    chk(sampling == (m_state < 2), {cur, " sampling"}, sampling, m_state < 2);
    chk(rd_valid == (m_state == 3), {cur, " rd_valid R6"}, rd_valid, m_state == 3);
    if (m_state >= 2) chk(int'(stop_addr) == m_stop, {cur, " stop address"}, stop_addr, m_stop);
    if (m_state == 3) begin
      chk(int'(rd_ch) == m_addr / 1024, "R7 channel", rd_ch, m_addr / 1024);
      chk(int'(rd_cell) == m_addr % 1024, "R7 cell", rd_cell, m_addr % 1024);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic pulse(input bit t, input bit g, input bit r);
    trig = t; rd_go = g; rearm = r;
    tick();
    trig = 0; rd_go = 0; rearm = 0;
  endtask

  task automatic run_to(input int a);
    while (int'(wr_cell) != a) tick();
  endtask

  task automatic read_count(output int n);
    n = 0;
    while (rd_valid && n < 9000) begin n++; tick(); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, s;
    repeat (3) @(negedge clk);
    chk(wr_cell == 0, "R1 reset address", wr_cell, 0);
    chk(sampling == 1, "R1 reset sampling", sampling, 1);
    chk(rd_valid == 0, "R1 reset valid", rd_valid, 0);
    rst_n = 1;

    cur = "R2";
    run_to(1023);
    tick();
    chk(wr_cell == 0, "R2 wrap at 1024", wr_cell, 0);

    cur = "R3";
    run_to(990);
    pulse(1, 0, 0);
    chk(stop_addr == 990, "R3 stop address", stop_addr, 990);
    chk(sampling == 0, "R3 halted", sampling, 0);
    cur = "R5";
    trig = 1; repeat (3) tick(); trig = 0;
    chk(stop_addr == 990 && wr_cell == 990, "R5 trigger while stopped", stop_addr, 990);
    cur = "R6";
    pulse(0, 1, 0);
    for (int i = 0; i < 100; i++) begin
      chk(rd_valid == 1, "R6 valid window", rd_valid, 1);
      chk(int'({rd_ch, rd_cell}) == (990 + i) % 1024, "R6 address order", {rd_ch, rd_cell}, (990 + i) % 1024);
      tick();
    end
    chk(rd_valid == 0, "R6 exactly N cycles", rd_valid, 0);
    chk(sampling == 1, "R8 resume", sampling, 1);
    cur = "R8";
    tick();
    chk(wr_cell == 991, "R8 advances from stop cell", wr_cell, 991);

    cur = "R4";
    cfg_mode = 1; cfg_delay = 5; cfg_roi = 8;
    run_to(2040);
    pulse(1, 0, 0);
    pulse(1, 0, 0);
    repeat (3) tick();
    chk(sampling == 1 && wr_cell == 2045, "R4 still sampling during delay", wr_cell, 2045);
    tick();
    chk(sampling == 0 && stop_addr == 2045, "R4 delayed stop (R5 retrigger ignored)", stop_addr, 2045);
    pulse(0, 1, 0);
    chk(rd_ch == 1 && rd_cell == 1021, "R7 chained channel 1", {rd_ch, rd_cell}, 2045);
    repeat (3) tick();
    chk(rd_ch == 0 && rd_cell == 0, "R7 wrap in 2048 ring", {rd_ch, rd_cell}, 0);
    read_count(n);
    chk(n == 5, "R6 remaining count", n, 5);

    cur = "R10";
    pulse(0, 1, 0);
    chk(rd_valid == 0 && sampling == 1, "R10 strobe while running", rd_valid, 0);

    cur = "R9";
    cfg_delay = 0;
    pulse(1, 0, 0);
    s = stop_addr;
    pulse(0, 1, 0);
    repeat (2) tick();
    pulse(0, 0, 1);
    chk(rd_valid == 0 && sampling == 1, "R9 rearm during read", rd_valid, 0);
    pulse(1, 0, 0);
    s = stop_addr;
    pulse(0, 0, 1);
    chk(sampling == 1 && int'(wr_cell) == s, "R9 rearm while stopped", wr_cell, s);

    cur = "R6";
    cfg_mode = 2; cfg_roi = 5000;
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    read_count(n);
    chk(n == 4096, "R6 oversize ROI clamps to ring", n, 4096);

    cfg_mode = 3; cfg_roi = 0;
    run_to(8000);
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    chk(rd_ch == 7, "R7 channel 7 in single ring", rd_ch, 7);
    read_count(n);
    chk(n + 1 == 8193, "R6 ROI 0 reads whole 8192 ring", n, 8192);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule